// File: doc/BRIEF.md
# Playback Status Output Generator

This block turns the start and done events of a voice playback sequencer into the status signals seen on three general-purpose output pins. It keeps a busy flag, produces a stop pulse of fixed length after playback ends, and makes a pair of complementary flashing lamp signals while playback runs. All timing is counted in sample ticks, so pulse width and flash rate follow the playback oscillator. At the default settings this gives a 64 ms pulse and about 3 Hz flashing at an 8 kHz sample rate.

A 2-bit chip-wide option picks one of four fixed assignments of these signals to the pins. The sequencer supplies a per-group enable with each done event. That enable decides whether the stop pulse is produced for the group that just finished. A new start cancels a stop pulse that is pending or running.

Top module: `psg_status_out`

## Requirements
- R1: `busy` goes high in the clock cycle after `playStart` is sampled and goes low in the clock cycle after `playDone` is sampled. In this block, `busy` is the signal routed to the pins.
- R2: A done event produces a stop pulse only when `stopEn` is high in the same cycle. When `stopEn` is low, the stop signal stays low.
- R3: The stop pulse rises in the cycle after the first `sampleTick` that follows the done event. It stays high for exactly `STOP_TICKS` sample ticks.
- R4: A `playStart` that arrives while a stop pulse is pending or high clears the pulse. The stop signal is low from the next cycle.
- R5: While busy, lamp A starts low. It toggles after every `LED_HALF` sample ticks. Lamp B is the complement of lamp A while busy. Both lamps are low while idle.
- R6: A `playStart` that arrives while already busy restarts the flash phase, so lamp A is low and a full `LED_HALF` ticks pass before it next toggles.
- R7: The pins are routed by `outOpt` as follows. With 00: out1 = lamp B, out2 = lamp A, out3 = busy. With 01: out1 = stop, out2 = lamp A, out3 = lamp B. With 10: out1 = lamp A, out2 = busy, out3 = stop. With 11: out1 = lamp A, out2 = busy, out3 = inverted busy.
- R8: In reset, all pins are low, except out3 under option 11, which is high.
- R9: When `playStart` and `playDone` arrive in the same cycle, the start wins. The block ends up busy with no stop pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| sampleTick | input | 1 | One-cycle pulse at the sample rate |
| playStart | input | 1 | One-cycle playback start (or retrigger) event |
| playDone | input | 1 | One-cycle playback end event |
| stopEn | input | 1 | Stop-pulse enable of the finishing group, sampled with playDone |
| outOpt | input | 2 | Pin assignment option |
| out1 | output | 1 | Status pin 1 |
| out2 | output | 1 | Status pin 2 |
| out3 | output | 1 | Status pin 3 |

## Verification
The hardest situations to reach are a start that lands in the short window between a done event and the next sample tick, and a start that lands inside a running stop pulse. In the first case the pulse is pending but not yet visible; in the second it is already high. The bench drives the sample tick itself on a fixed four-cycle phase, so it can place a start exactly one cycle after a done (before any tick) or several ticks into the pulse. It repeats every such sequence under all four pin options and both enable values, and compares every pin in every cycle with a model built from the requirements.

// File: rtl/psg_pkg.sv
package psg_pkg;

  // Strobes from the control to the counter datapath
  typedef struct packed {
    logic ledClr;    // restart flash phase and counter
    logic ledAdv;    // count one sample tick of flash time
    logic stopLoad;  // begin stop pulse, load its length
    logic stopAdv;   // count one sample tick of stop time
  } psg_strobe_t;

  typedef enum logic [1:0] {
    MAP_B_A_BUSY    = 2'b00,
    MAP_STOP_A_B    = 2'b01,
    MAP_A_BUSY_STOP = 2'b10,
    MAP_A_BUSY_NBSY = 2'b11
  } psg_map_e;

endpackage

// File: rtl/psg_ctrl.sv
module psg_ctrl
  import psg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleTick,
  input  logic        playStart,
  input  logic        playDone,
  input  logic        stopEn,
  input  logic        ledWrap,
  input  logic        stopLast,
  output psg_strobe_t strb,
  output logic        busy,
  output logic        stopOn
);

  logic armed;

  always_comb begin
    strb.ledClr   = playStart | playDone;
    strb.ledAdv   = busy & sampleTick & ~(playStart | playDone);
    strb.stopLoad = armed & sampleTick & ~playStart & ~playDone;
    strb.stopAdv  = stopOn & sampleTick & ~playStart & ~strb.stopLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      armed  <= 1'b0;
      stopOn <= 1'b0;
    end else begin
      if (playStart)     busy <= 1'b1;
      else if (playDone) busy <= 1'b0;

      if (playStart)                   armed <= 1'b0;
      else if (playDone)               armed <= stopEn;
      else if (armed && sampleTick)    armed <= 1'b0;

      if (playStart)                         stopOn <= 1'b0;
      else if (strb.stopLoad)                stopOn <= 1'b1;
      else if (strb.stopAdv && stopLast)     stopOn <= 1'b0;
    end
  end

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rstN)
    playStart |=> busy);                                       // R1
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (playDone && !playStart) |=> !busy);                       // R1
  AST_STOP_FROM_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (!stopOn ##1 stopOn) |-> $past(armed));                    // R2
  AST_STOP_KILL: assert property (@(posedge clk) disable iff (!rstN)
    playStart |=> (!stopOn && !armed));                        // R4
  AST_START_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (playStart && playDone) |=> (busy && !armed));             // R9

endmodule

// File: rtl/psg_dpath.sv
module psg_dpath
  import psg_pkg::*;
#(
  parameter int STOP_TICKS = 512,
  parameter int LED_HALF   = 1333
) (
  input  logic        clk,
  input  logic        rstN,
  input  psg_strobe_t strb,
  output logic        ledWrap,
  output logic        stopLast,
  output logic        ledPhase
);

  localparam int LW = (LED_HALF > 1) ? $clog2(LED_HALF) : 1;
  localparam int SW = $clog2(STOP_TICKS + 1);
  localparam logic [LW-1:0] LED_LAST = LW'(LED_HALF - 1);
  localparam logic [SW-1:0] STOP_LEN = SW'(STOP_TICKS);

  logic [LW-1:0] ledCnt;
  logic [SW-1:0] stopCnt;

  assign ledWrap  = (ledCnt == LED_LAST);
  assign stopLast = (stopCnt == SW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledCnt   <= '0;
      ledPhase <= 1'b0;
    end else if (strb.ledClr) begin
      ledCnt   <= '0;
      ledPhase <= 1'b0;
    end else if (strb.ledAdv) begin
      if (ledWrap) begin
        ledCnt   <= '0;
        ledPhase <= ~ledPhase;
      end else begin
        ledCnt <= ledCnt + LW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              stopCnt <= '0;
    else if (strb.stopLoad) stopCnt <= STOP_LEN;
    else if (strb.stopAdv)  stopCnt <= stopCnt - SW'(1);
  end

  AST_LED_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ledCnt <= LED_LAST);                                       // R5
  AST_LED_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.ledClr |=> (!ledPhase && ledCnt == '0));              // R6
  AST_STOP_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    strb.stopLoad |=> (stopCnt == STOP_LEN));                  // R3

endmodule

// File: rtl/psg_route.sv
module psg_route
  import psg_pkg::*;
(
  input  logic [1:0] outOpt,
  input  logic       busy,
  input  logic       stopP,
  input  logic       lampA,
  input  logic       lampB,
  output logic       out1,
  output logic       out2,
  output logic       out3
);

  always_comb begin
    unique case (psg_map_e'(outOpt))
      MAP_B_A_BUSY:    begin out1 = lampB; out2 = lampA; out3 = busy;  end
      MAP_STOP_A_B:    begin out1 = stopP; out2 = lampA; out3 = lampB; end
      MAP_A_BUSY_STOP: begin out1 = lampA; out2 = busy;  out3 = stopP; end
      default:         begin out1 = lampA; out2 = busy;  out3 = ~busy; end
    endcase
  end

endmodule

// File: rtl/psg_status_out.sv
module psg_status_out
  import psg_pkg::*;
#(
  parameter int STOP_TICKS = 512,
  parameter int LED_HALF   = 1333
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       playStart,
  input  logic       playDone,
  input  logic       stopEn,
  input  logic [1:0] outOpt,
  output logic       out1,
  output logic       out2,
  output logic       out3
);

  psg_strobe_t strb;
  logic busy, stopOn, ledWrap, stopLast, ledPhase;
  logic lampA, lampB;

  psg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick),
    .playStart(playStart), .playDone(playDone), .stopEn(stopEn),
    .ledWrap(ledWrap), .stopLast(stopLast),
    .strb(strb), .busy(busy), .stopOn(stopOn)
  );

  psg_dpath #(.STOP_TICKS(STOP_TICKS), .LED_HALF(LED_HALF)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ledWrap(ledWrap), .stopLast(stopLast), .ledPhase(ledPhase)
  );

  assign lampA = busy & ledPhase;
  assign lampB = busy & ~ledPhase;

  psg_route u_route (
    .outOpt(outOpt), .busy(busy), .stopP(stopOn),
    .lampA(lampA), .lampB(lampB),
    .out1(out1), .out2(out2), .out3(out3)
  );

  AST_LAMP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(lampA && lampB));                                        // R5
  AST_LAMP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!lampA && !lampB));                             // R5
  AST_OPT4_NBUSY: assert property (@(posedge clk) disable iff (!rstN)
    (outOpt == 2'b11) |-> (out2 != out3));                     // R7
  AST_NO_STOP_PIN_OPT0: assert property (@(posedge clk) disable iff (!rstN)
    (outOpt == 2'b00 && !busy) |-> (!out1 && !out2 && !out3)); // R7

endmodule

// File: tb/psg_status_out_tb.sv
module psg_status_out_tb;

  localparam int ST = 5;   // stop pulse length in ticks
  localparam int LH = 3;   // flash half period in ticks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0, playStart = 1'b0, playDone = 1'b0, stopEn = 1'b0;
  logic [1:0] outOpt = 2'b00;
  logic out1, out2, out3;

  int errors = 0;
  int checks = 0;
  int tph = 0;
  int cycles = 0;
  bit finished = 0;

  // model state
  bit mBusy, mArm, mStop, mLed;
  int mStopCnt, mLedCnt;

  always #4 clk = ~clk;  // 125 MHz

  psg_status_out #(.STOP_TICKS(ST), .LED_HALF(LH)) u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick),
    .playStart(playStart), .playDone(playDone), .stopEn(stopEn),
    .outOpt(outOpt), .out1(out1), .out2(out2), .out3(out3)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at t=%0t: actual=%b expected=%b", tag, $time, got, exp);
    end
  endtask

  task automatic modelStep(input bit s, input bit d, input bit t);
    // stop path
    if (s) begin
      mStop = 0; mArm = 0;
    end else begin
      if (mArm && t && !d) begin
        mStop = 1; mStopCnt = ST; mArm = 0;
      end else if (mStop && t) begin
        if (mStopCnt == 1) mStop = 0;
        else mStopCnt--;
      end
      if (d) mArm = stopEn;
    end
    // flash path (uses busy before update)
    if (s || d) begin
      mLedCnt = 0; mLed = 0;
    end else if (mBusy && t) begin
      if (mLedCnt == LH - 1) begin
        mLedCnt = 0; mLed = ~mLed;
      end else mLedCnt++;
    end
    if (s) mBusy = 1;
    else if (d) mBusy = 0;
  endtask

  task automatic comparePins(input string tag);
    bit a, b, e1, e2, e3;
    a = mBusy & mLed;
    b = mBusy & ~mLed;
    case (outOpt)
      2'b00: begin e1 = b;     e2 = a;     e3 = mBusy;  end
      2'b01: begin e1 = mStop; e2 = a;     e3 = b;      end
      2'b10: begin e1 = a;     e2 = mBusy; e3 = mStop;  end
      default: begin e1 = a;   e2 = mBusy; e3 = ~mBusy; end
    endcase
    chk({tag, " out1"}, out1, e1);
    chk({tag, " out2"}, out2, e2);
    chk({tag, " out3"}, out3, e3);
  endtask

  task automatic cyc(input bit s, input bit d, input string tag);
    playStart = s; playDone = d;
    sampleTick = (tph == 3);
    tph = (tph + 1) % 4;
    modelStep(s, d, sampleTick);
    @(posedge clk); @(negedge clk);
    playStart = 0; playDone = 0; sampleTick = 0;
    comparePins(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, tag);
  endtask

  task automatic scen(input int k, input string tag);
    case (k)
      0: begin  // plain playback: R1 R3 R5 R2
        cyc(1, 0, tag); idle(4*LH*3 + 5, tag);
        cyc(0, 1, tag); idle(4*(ST + 3), tag);
      end
      1: begin  // start cuts a running pulse: R4
        cyc(1, 0, tag); idle(10, tag);
        cyc(0, 1, tag); idle(10, tag);
        cyc(1, 0, tag); idle(20, tag);
        cyc(0, 1, tag); idle(4*(ST + 3), tag);
      end
      2: begin  // retrigger while busy: R6
        cyc(1, 0, tag); idle(17, tag);
        cyc(1, 0, tag); idle(30, tag);
        cyc(0, 1, tag); idle(4*(ST + 3), tag);
      end
      3: begin  // simultaneous start and done: R9
        cyc(1, 1, tag); idle(9, tag);
        cyc(0, 1, tag); idle(4*(ST + 3), tag);
      end
      default: begin  // start while pulse only pending: R4
        cyc(1, 0, tag); idle(6, tag);
        while (tph == 3) cyc(0, 0, tag);
        cyc(0, 1, tag);
        cyc(1, 0, tag); idle(12, tag);
        cyc(0, 1, tag); idle(4*(ST + 3), tag);
      end
    endcase
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !finished) begin
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    string tags[5];
    tags[0] = "R1_R2_R3_R5_R7";
    tags[1] = "R4_R7";
    tags[2] = "R6_R7";
    tags[3] = "R9_R7";
    tags[4] = "R4_pending_R7";
    mBusy = 0; mArm = 0; mStop = 0; mLed = 0; mStopCnt = 0; mLedCnt = 0;
    repeat (3) @(negedge clk);
    // R8 reset values under every option
    for (int o = 0; o < 4; o++) begin
      outOpt = 2'(o);
      @(negedge clk);
      chk($sformatf("R8 opt%0d out1", o), out1, 1'b0);
      chk($sformatf("R8 opt%0d out2", o), out2, 1'b0);
      chk($sformatf("R8 opt%0d out3", o), out3, (o == 3));
    end
    rstN = 1'b1;
    @(negedge clk);
    for (int o = 0; o < 4; o++) begin
      for (int e = 0; e < 2; e++) begin
        for (int k = 0; k < 5; k++) begin
          outOpt = 2'(o);
          stopEn = e[0];
          scen(k, $sformatf("%s opt%0d en%0d", tags[k], o, e));
        end
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule